// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block supplies the address a synchronous memory uses on every cycle of a four-beat burst. A load cycle captures a full external address. That address becomes the first beat. Each later continue cycle moves only the two lowest address bits to the next beat. The upper bits stay exactly as they were loaded.

A static order input chooses between two beat orders, and it is sampled only when an address is loaded. In the linear order the two low bits count upward and wrap. In the interleaved order each beat equals the start offset XOR a two-bit beat count, and that count clears on every load. A continue request after the fourth beat does not end the burst: the count wraps and the same four offsets repeat.

An active-high stall input makes the block ignore the clock edge, so every register keeps its value. Reset is synchronous.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset sets `addr_o` to all zeros, clears the beat count and selects the linear order (order code 0).
- R2: On a load cycle (`stall_i`=0, `load_i`=1), `addr_o` equals `addr_i` after the clock edge.
- R3: In linear order (`interleave_i`=0 when loaded), each continue cycle (`stall_i`=0, `load_i`=0, `advance_i`=1) sets bits [1:0] of `addr_o` to their previous value plus one modulo 4. For example, a start of 2 gives 2, 3, 0, 1.
- R4: In interleaved order (`interleave_i`=1 when loaded), beat n has bits [1:0] equal to start XOR n. A start of 1 gives 1, 0, 3, 2, and a start of 3 gives 3, 2, 1, 0.
- R5: A continue cycle never changes `addr_o` bits [ADDR_W-1:2].
- R6: While `stall_i` is 1, `addr_o` holds its value whatever `load_i`, `advance_i`, `addr_i` and `interleave_i` do.
- R7: A continue cycle after the fourth beat returns to the start offset, and the same sequence repeats.
- R8: `interleave_i` is sampled only on load cycles. A change during a burst does not alter the order of that burst.
- R9: A cycle without stall, load or continue leaves `addr_o` unchanged.
- R10: When `load_i` and `advance_i` are both 1 and there is no stall, the load wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | When 1, the clock edge is ignored and all state holds |
| load_i | input | 1 | Captures `addr_i` and starts a new burst |
| advance_i | input | 1 | Steps to the next beat of the burst |
| addr_i | input | ADDR_W | External start address |
| interleave_i | input | 1 | Beat order: 0 linear, 1 interleaved; sampled on load |
| addr_o | output | ADDR_W | Address for the current cycle |

## Verification
The checker assumes that reset is asserted at least once before the continue and order properties mean anything. It also assumes that the stall, load and advance strobes are always 0 or 1, never unknown. The bench drives reset for several cycles at the start. It changes every input just after the falling clock edge, so each strobe is a clean level at the rising edge. The bench also changes `interleave_i` during a burst on purpose, because the order properties are meant to hold across such changes.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Number of beats in one burst and width of the beat offset.
  localparam int BURST_BEATS = 4;
  localparam int BEAT_W      = $clog2(BURST_BEATS);

  typedef enum logic {
    ORDER_LINEAR     = 1'b0,
    ORDER_INTERLEAVE = 1'b1
  } order_e;

  // Offset of beat n in linear order: count up from the start, wrapping.
  function automatic logic [BEAT_W-1:0] linear_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] n
  );
    return start + n;
  endfunction

  // Offset of beat n in interleaved order: start XOR beat count.
  function automatic logic [BEAT_W-1:0] interleave_offset(
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] n
  );
    return start ^ n;
  endfunction

  // Offset of beat n in the selected order.
  function automatic logic [BEAT_W-1:0] beat_offset(
    input order_e            ord,
    input logic [BEAT_W-1:0] start,
    input logic [BEAT_W-1:0] n
  );
    return (ord == ORDER_INTERLEAVE) ? interleave_offset(start, n)
                                     : linear_offset(start, n);
  endfunction
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  // Clear wins over step. The count wraps naturally after the last beat.
  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
    end else if (clear_i) begin
      beat_q <= '0;
    end else if (step_i) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign beat_o = beat_q;
endmodule

// File: rtl/burst_start_reg.sv
module burst_start_reg
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     capture_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     interleave_i,
  output logic [ADDR_W-BEAT_W-1:0] upper_o,
  output logic [BEAT_W-1:0]        start_o,
  output order_e                   order_o
);
  logic [ADDR_W-BEAT_W-1:0] upper_q;
  logic [BEAT_W-1:0]        start_q;
  order_e                   order_q;

  // Upper bits, start offset and beat order change only on a capture.
  always_ff @(posedge clk) begin
    if (rst) begin
      upper_q <= '0;
      start_q <= '0;
      order_q <= ORDER_LINEAR;
    end else if (capture_i) begin
      upper_q <= addr_i[ADDR_W-1:BEAT_W];
      start_q <= addr_i[BEAT_W-1:0];
      order_q <= interleave_i ? ORDER_INTERLEAVE : ORDER_LINEAR;
    end
  end

  assign upper_o = upper_q;
  assign start_o = start_q;
  assign order_o = order_q;
endmodule

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order_i,
  input  logic [BEAT_W-1:0] start_i,
  input  logic [BEAT_W-1:0] beat_i,
  output logic [BEAT_W-1:0] offset_o
);
  always_comb begin
    offset_o = beat_offset(order_i, start_i, beat_i);
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall_i,
  input  logic              load_i,
  input  logic              advance_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              interleave_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  // Named events, brought out for the checker.
  logic load_evt;
  logic adv_evt;
  assign load_evt = !stall_i && load_i;
  assign adv_evt  = !stall_i && !load_i && advance_i;

  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q;
  order_e             order_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  offset;

  burst_start_reg #(.ADDR_W(ADDR_W), .BEAT_W(BEAT_W)) u_start (
    .clk          (clk),
    .rst          (rst),
    .capture_i    (load_evt),
    .addr_i       (addr_i),
    .interleave_i (interleave_i),
    .upper_o      (upper_q),
    .start_o      (start_q),
    .order_o      (order_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk     (clk),
    .rst     (rst),
    .clear_i (load_evt),
    .step_i  (adv_evt),
    .beat_o  (beat_q)
  );

  burst_offset_map #(.BEAT_W(BEAT_W)) u_map (
    .order_i  (order_q),
    .start_i  (start_q),
    .beat_i   (beat_q),
    .offset_o (offset)
  );

  assign addr_o = {upper_q, offset};
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              stall_i,
  input logic              load_i,
  input logic              advance_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic              load_evt,
  input logic              adv_evt,
  input order_e            order_q,
  input logic [BEAT_W-1:0] start_q,
  input logic [BEAT_W-1:0] beat_q
);
  // R1: the cycle after reset shows a zero address
  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (addr_o == '0 && beat_q == '0));

  // R2: a load makes the sampled address visible
  assert_load_capture_R2: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (addr_o == $past(addr_i)));

  // R3: linear continue adds one to the low bits
  assert_linear_step_R3: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && order_q == ORDER_LINEAR) |=>
      (addr_o[BEAT_W-1:0] == $past(addr_o[BEAT_W-1:0]) + 2'd1));

  // R4: interleaved continue gives start XOR the new beat count
  assert_interleave_step_R4: assert property (@(posedge clk) disable iff (rst)
    (adv_evt && order_q == ORDER_INTERLEAVE) |=>
      ((addr_o[BEAT_W-1:0] ^ start_q) == $past(beat_q) + 2'd1));

  // R5: a continue leaves the upper bits alone
  assert_upper_stable_R5: assert property (@(posedge clk) disable iff (rst)
    adv_evt |=> $stable(addr_o[ADDR_W-1:BEAT_W]));

  // R6: a stall freezes the address
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    stall_i |=> $stable(addr_o));

  // R9: an idle cycle freezes the address
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!stall_i && !load_i && !advance_i) |=> $stable(addr_o));

  // R10: load wins over a simultaneous continue
  assert_load_priority_R10: assert property (@(posedge clk) disable iff (rst)
    (load_evt && advance_i) |=> (beat_q == '0));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .stall_i   (stall_i),
  .load_i    (load_i),
  .advance_i (advance_i),
  .addr_i    (addr_i),
  .addr_o    (addr_o),
  .load_evt  (load_evt),
  .adv_evt   (adv_evt),
  .order_q   (order_q),
  .start_q   (start_q),
  .beat_q    (beat_q)
);

// File: tb/burst_addr_seq_test.sv
module burst_addr_seq_test;
  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          stall_i = 1'b0;
  logic          load_i = 1'b0;
  logic          advance_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic          interleave_i = 1'b0;
  logic [AW-1:0] addr_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) uut (
    .clk          (clk),
    .rst          (rst),
    .stall_i      (stall_i),
    .load_i       (load_i),
    .advance_i    (advance_i),
    .addr_i       (addr_i),
    .interleave_i (interleave_i),
    .addr_o       (addr_o)
  );

  typedef struct packed {
    logic          ld;
    logic          adv;
    logic          stl;
    logic          ilv;
    logic [AW-1:0] addr;
    logic [AW-1:0] exp;
  } vec_t;

  localparam logic [AW-1:0] U = 17'h0F3A0;
  localparam logic [AW-1:0] V = 17'h12340;
  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, U | 17'd2, U | 17'd2},  // R2 linear load
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        U | 17'd3},  // R3
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        U | 17'd0},  // R3 wrap 3->0, R5
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        U | 17'd1},  // R3
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        U | 17'd2},  // R7 fifth beat
    '{1'b0, 1'b0, 1'b0, 1'b0, 17'h1FFFF, U | 17'd2},  // R9 idle
    '{1'b0, 1'b1, 1'b1, 1'b1, '0,        U | 17'd2},  // R6 stalled continue
    '{1'b1, 1'b0, 1'b1, 1'b1, 17'h00011, U | 17'd2},  // R6 stalled load
    '{1'b1, 1'b0, 1'b0, 1'b1, V | 17'd1, V | 17'd1},  // R2 interleaved load
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        V | 17'd0},  // R4, R8 mode dropped
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        V | 17'd3},  // R4, R8
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        V | 17'd2},  // R4
    '{1'b0, 1'b1, 1'b0, 1'b0, '0,        V | 17'd1},  // R7 interleaved wrap
    '{1'b1, 1'b1, 1'b0, 1'b1, V | 17'd3, V | 17'd3},  // R10 load beats continue
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        V | 17'd2},  // R4
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        V | 17'd1},  // R4
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        V | 17'd0},  // R4
    '{1'b1, 1'b0, 1'b0, 1'b1, V | 17'd2, V | 17'd2},  // R2
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        V | 17'd3},  // R4
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        V | 17'd0},  // R4
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        V | 17'd1},  // R4
    '{1'b1, 1'b0, 1'b0, 1'b0, U | 17'd1, U | 17'd1},  // R2
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        U | 17'd2},  // R8 linear kept
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        U | 17'd3},  // R3
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        U | 17'd0},  // R3
    '{1'b0, 1'b1, 1'b0, 1'b1, '0,        U | 17'd1}   // R7
  };

  task automatic check(input string req, input logic [AW-1:0] act,
                       input logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: addr_o=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive after the falling edge, let one rising edge pass, sample at the next fall.
  task automatic cycle(input logic ld, input logic adv, input logic stl,
                       input logic ilv, input logic [AW-1:0] a);
    load_i = ld; advance_i = adv; stall_i = stl; interleave_i = ilv; addr_i = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  // Reference sequences written as explicit lists.
  function automatic logic [1:0] ref_beat(input bit ilv, input logic [1:0] s,
                                          input int n);
    logic [1:0] lin [4][4];
    logic [1:0] itl [4][4];
    lin = '{'{0,1,2,3}, '{1,2,3,0}, '{2,3,0,1}, '{3,0,1,2}};
    itl = '{'{0,1,2,3}, '{1,0,3,2}, '{2,3,0,1}, '{3,2,1,0}};
    return ilv ? itl[s][n % 4] : lin[s][n % 4];
  endfunction

  initial begin
    @(negedge clk);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, '0);
    cycle(1'b0, 1'b0, 1'b0, 1'b0, '0);
    check("R1 reset state", addr_o, '0);
    rst = 1'b0;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, '0);
    check("R1 linear after reset", addr_o, 17'd1);

    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].ld, VECS[i].adv, VECS[i].stl, VECS[i].ilv, VECS[i].addr);
      check($sformatf("vector %0d (R2..R10)", i), addr_o, VECS[i].exp);
    end

    // R3 R4 R7: every start, both orders, two full passes
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        logic [AW-1:0] base;
        base = 17'h0A5C0 | AW'(s);
        cycle(1'b1, 1'b0, 1'b0, m[0], base);
        check(m == 1 ? "R4 start" : "R3 start", addr_o, base);
        for (int n = 1; n < 9; n++) begin
          cycle(1'b0, 1'b1, 1'b0, ~m[0], '0);
          check(m == 1 ? "R4 R7 beat" : "R3 R7 beat", addr_o,
                {base[AW-1:2], ref_beat(m[0], 2'(s), n)});
        end
      end
    end

    // R1: reset in mid-burst
    cycle(1'b1, 1'b0, 1'b0, 1'b1, 17'h1FFFF);
    cycle(1'b0, 1'b1, 1'b0, 1'b1, '0);
    rst = 1'b1;
    cycle(1'b0, 1'b1, 1'b0, 1'b1, '0);
    check("R1 mid-burst reset", addr_o, '0);
    rst = 1'b0;
    cycle(1'b0, 1'b1, 1'b0, 1'b0, '0);
    cycle(1'b0, 1'b1, 1'b0, 1'b0, '0);
    check("R1 order back to linear", addr_o, 17'd2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule